// File: doc/BRIEF.md
# Dual-Mode Reset Sequencer

This block turns an active-low external reset pin, a power-good level and a supply-lockout flag into the internal reset and access controls of a memory-and-logic subsystem. It tells a power-on reset apart from a warm reset. Each kind has its own minimum low-pulse width. After a qualifying pulse ends, the subsystem is held in reset for a fixed recovery window. Only then are memory selects and the write strobe passed through from the host side.

A reset is treated as power-on when power-good has been low at any time since the last completed reset. Otherwise it is warm. Power-on resets clear the page-map registers and force the output macrocell flip-flops to 0. Warm resets keep the page map and let the macrocells take their programmed reset/preset inputs. Both kinds send the I/O ports to input mode and clear the general registers. Logic outputs are flagged invalid only between power-up and the end of configuration load.

Top module: `rst_seq`

## Requirements
- R1: While pwr_good is 0, the block is in its power-off state: access_en=0, logic_valid=0, por_kind=1, and io_input_mode, gen_clr, page_clr and mc_clr are all 1.
- R2: After pwr_good rises, logic_valid stays 0 for CFG_CYC+1 rising edges (one edge to leave power-off, then CFG_CYC edges of configuration load), and is 1 from the next edge on.
- R3: After power-on, the sequence continues only on a low pulse of rst_pin_n lasting at least POR_MIN clock cycles. A shorter pulse leaves access_en at 0.
- R4: While access_en is 1, a low pulse shorter than WARM_MIN cycles is ignored and access_en stays 1. A pulse of WARM_MIN cycles or more starts a warm reset.
- R5: rst_pin_n passes through two synchronizing flip-flops. access_en rises on rising edge REC_CYC+3, counted from the first edge that samples the pin high after a qualifying pulse. The same count applies to both kinds of reset.
- R6: Whenever access_en is 0, mem_sel is all zeros and mem_wr_n is 1. When access_en is 1, mem_sel equals host_sel.
- R7: When vdd_low is 1, mem_wr_n is 1 even with access_en at 1. Otherwise, when access is enabled, mem_wr_n follows host_wr_n.
- R8: During a power-on reset, por_kind=1, page_clr=1, mc_clr=1 and mc_rp_en=0.
- R9: During a warm reset, por_kind=0, gen_clr=1, io_input_mode=1, page_clr=0, mc_clr=0 and mc_rp_en=1, and logic_valid stays 1.
- R10: A low on the synchronized pin during the recovery window cancels the recovery count. A new pulse of the required minimum width must then complete, followed by a full recovery window.
- R11: A drop of pwr_good at any time makes the next reset a power-on reset, which needs POR_MIN cycles rather than WARM_MIN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_good | input | 1 | Supply good level; 0 forces power-off state |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| vdd_low | input | 1 | Supply below write-lockout threshold |
| host_sel | input | NSEL | Requested sector and boot selects, active high |
| host_wr_n | input | 1 | Requested write strobe, active low |
| access_en | output | 1 | Memory access permitted |
| logic_valid | output | 1 | Configurable logic outputs valid |
| por_kind | output | 1 | Current or last reset is of the power-on kind |
| mem_sel | output | NSEL | Gated sector and boot selects |
| mem_wr_n | output | 1 | Gated write strobe, active low |
| io_input_mode | output | 1 | Force I/O port configuration to input |
| gen_clr | output | 1 | Clear general registers |
| page_clr | output | 1 | Clear page-map and control registers |
| mc_clr | output | 1 | Force macrocell flip-flops to 0 |
| mc_rp_en | output | 1 | Let macrocells take programmed reset/preset |

## Verification
A table of warm pulse lengths around WARM_MIN (1, 3, 4, 5, 12 cycles) is applied from the operational state. These cases separate ignored glitches from accepted resets, and they check the exact edge at which access returns. Power-on pulses one cycle below and exactly at POR_MIN show that the longer limit applies only after a power-good drop. A short pulse inside the recovery window separates cancellation from a restart that accepts any pulse. Toggling vdd_low in operation separates the lockout from the access gate.

// File: rtl/rst_seq.sv
module rst_seq #(
  parameter int POR_MIN  = 40,
  parameter int WARM_MIN = 4,
  parameter int REC_CYC  = 16,
  parameter int CFG_CYC  = 8,
  parameter int NSEL     = 8
) (
  input  logic            clk,
  input  logic            pwr_good,
  input  logic            rst_pin_n,
  input  logic            vdd_low,
  input  logic [NSEL-1:0] host_sel,
  input  logic            host_wr_n,
  output logic            access_en,
  output logic            logic_valid,
  output logic            por_kind,
  output logic [NSEL-1:0] mem_sel,
  output logic            mem_wr_n,
  output logic            io_input_mode,
  output logic            gen_clr,
  output logic            page_clr,
  output logic            mc_clr,
  output logic            mc_rp_en
);
  localparam int LW   = $clog2(POR_MIN + 1);
  localparam int CMAX = (REC_CYC > CFG_CYC) ? REC_CYC : CFG_CYC;
  localparam int CW   = $clog2(CMAX + 1);

  typedef enum logic [2:0] {S_OFF, S_CFG, S_INR, S_REC, S_OPER} st_t;

  st_t           state;
  logic          s1, s2, por;
  logic [LW-1:0] lo_cnt, next_lo, min_sel;
  logic [CW-1:0] cnt;
  logic          in_rst;

  assign next_lo = s2 ? '0 : ((lo_cnt == LW'(POR_MIN)) ? lo_cnt : lo_cnt + 1'b1);
  assign min_sel = por ? LW'(POR_MIN) : LW'(WARM_MIN);

  always_ff @(posedge clk) begin
    if (!pwr_good) begin
      s1     <= 1'b1;
      s2     <= 1'b1;
      lo_cnt <= '0;
      cnt    <= '0;
      por    <= 1'b1;
      state  <= S_OFF;
    end else begin
      s1     <= rst_pin_n;
      s2     <= s1;
      lo_cnt <= next_lo;
      case (state)
        S_OFF: begin
          state <= S_CFG;
          cnt   <= '0;
        end
        S_CFG:
          if (cnt == CW'(CFG_CYC - 1)) begin
            state <= S_INR;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        S_INR:
          if (s2 && (lo_cnt >= min_sel)) begin
            state <= S_REC;
            cnt   <= '0;
          end
        S_REC:
          if (!s2) begin
            state <= S_INR;
            cnt   <= '0;
          end else if (cnt == CW'(REC_CYC - 1)) begin
            state <= S_OPER;
            por   <= 1'b0;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        S_OPER:
          if (next_lo >= LW'(WARM_MIN)) state <= S_INR;
        default: state <= S_OFF;
      endcase
    end
  end

  assign access_en     = (state == S_OPER);
  assign in_rst        = ~access_en;
  assign logic_valid   = (state != S_OFF) && (state != S_CFG);
  assign por_kind      = por;
  assign mem_sel       = host_sel & {NSEL{access_en}};
  assign mem_wr_n      = host_wr_n | in_rst | vdd_low;
  assign io_input_mode = in_rst;
  assign gen_clr       = in_rst;
  assign page_clr      = in_rst & por;
  assign mc_clr        = in_rst & por;
  assign mc_rp_en      = in_rst & ~por;

  // R2
  cfg_len_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    (state == S_INR && $past(state) == S_CFG) |-> $past(cnt) == CW'(CFG_CYC - 1));

  // R3
  por_width_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    (state == S_REC && $past(state) == S_INR && $past(por)) |-> $past(lo_cnt) >= LW'(POR_MIN));

  // R4
  warm_entry_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    (state == S_INR && $past(state) == S_OPER) |-> (!$past(s2) && !por));

  // R5
  rec_len_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    $rose(access_en) |-> ($past(state) == S_REC && $past(cnt) == CW'(REC_CYC - 1)));

  // R10
  rec_cancel_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    (state == S_REC && !s2) |=> (state == S_INR && !access_en));

  // R6
  wr_block_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    (state != S_OPER) |-> (mem_wr_n && mem_sel == '0));
endmodule

// File: tb/tb_rst_seq.sv
`timescale 1ns/1ps
module tb_rst_seq;
  localparam int POR_MIN = 40, WARM_MIN = 4, REC_CYC = 16, CFG_CYC = 8, NSEL = 8;

  logic clk = 1'b0;
  logic pwr_good = 1'b0, rst_pin_n = 1'b1, vdd_low = 1'b0, host_wr_n = 1'b0;
  logic [NSEL-1:0] host_sel = 8'hA5;
  logic access_en, logic_valid, por_kind, mem_wr_n, io_input_mode, gen_clr, page_clr, mc_clr, mc_rp_en;
  logic [NSEL-1:0] mem_sel;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rst_seq #(.POR_MIN(POR_MIN), .WARM_MIN(WARM_MIN), .REC_CYC(REC_CYC), .CFG_CYC(CFG_CYC), .NSEL(NSEL)) dut (
    .clk(clk), .pwr_good(pwr_good), .rst_pin_n(rst_pin_n), .vdd_low(vdd_low),
    .host_sel(host_sel), .host_wr_n(host_wr_n), .access_en(access_en), .logic_valid(logic_valid),
    .por_kind(por_kind), .mem_sel(mem_sel), .mem_wr_n(mem_wr_n), .io_input_mode(io_input_mode),
    .gen_clr(gen_clr), .page_clr(page_clr), .mc_clr(mc_clr), .mc_rp_en(mc_rp_en));

  // {pulse length, accepted}
  localparam logic [15:0] WARM_VEC [5] = '{
    {8'd1, 8'd0}, {8'd3, 8'd0}, {8'd4, 8'd1}, {8'd5, 8'd1}, {8'd12, 8'd1}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse(input int len);
    rst_pin_n = 1'b0;
    repeat (len) @(negedge clk);
    rst_pin_n = 1'b1;
  endtask

  // after release: access 0 after 2+REC edges, 1 after one more
  task automatic expect_recover(input string req);
    repeat (2 + REC_CYC) @(negedge clk);
    chk(req, access_en, 1'b0);
    @(negedge clk);
    chk(req, access_en, 1'b1);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 access", access_en, 0);
    chk("R1 valid", logic_valid, 0);
    chk("R1 clears", {io_input_mode, gen_clr, page_clr, mc_clr, por_kind}, 5'b11111);
    chk("R6 sel", mem_sel, 0);
    chk("R6 wr", mem_wr_n, 1);

    // R2 configuration load
    pwr_good = 1'b1;
    repeat (CFG_CYC) @(negedge clk);
    chk("R2 still loading", logic_valid, 0);
    @(negedge clk);
    chk("R2 valid", logic_valid, 1);
    // R8 power-on clear policy
    chk("R8 policy", {por_kind, page_clr, mc_clr, mc_rp_en}, 4'b1110);

    // R3 short power-on pulse
    pulse(POR_MIN - 1);
    repeat (REC_CYC + 8) @(negedge clk);
    chk("R3 short por", access_en, 0);
    pulse(POR_MIN);
    expect_recover("R5 por recovery");
    chk("R6 sel pass", mem_sel, 8'hA5);
    chk("R7 wr pass", mem_wr_n, 0);
    vdd_low = 1'b1;
    #1 chk("R7 lockout", mem_wr_n, 1);
    vdd_low = 1'b0;
    #1 chk("R7 release", mem_wr_n, 0);
    @(negedge clk);

    // R4 warm pulse table
    foreach (WARM_VEC[i]) begin
      int len = int'(WARM_VEC[i][15:8]);
      bit acc = WARM_VEC[i][0];
      if (!acc) begin
        pulse(len);
        for (int k = 0; k < len + 6; k++) begin
          @(negedge clk);
          if (access_en !== 1'b1) break;
        end
        chk("R4 glitch ignored", access_en, 1);
      end else begin
        pulse(len);
        @(negedge clk); @(negedge clk);
        chk("R9 warm policy", {por_kind, gen_clr, io_input_mode, page_clr, mc_clr, mc_rp_en, logic_valid}, 7'b0110011);
        chk("R6 blocked", {mem_sel, mem_wr_n}, {8'h00, 1'b1});
        repeat (REC_CYC) @(negedge clk);
        chk("R4 R5 warm hold", access_en, 0);
        @(negedge clk);
        chk("R4 R5 warm recover", access_en, 1);
      end
      repeat (3) @(negedge clk);
    end

    // R10 cancel during recovery
    pulse(6);
    repeat (5) @(negedge clk);
    pulse(2);
    repeat (REC_CYC + 10) @(negedge clk);
    chk("R10 cancelled", access_en, 0);
    pulse(WARM_MIN);
    expect_recover("R10 new window");

    // R11 power-good drop makes next reset power-on
    @(negedge clk);
    pwr_good = 1'b0;
    @(negedge clk);
    chk("R1 drop", {access_en, por_kind}, 2'b01);
    pwr_good = 1'b1;
    repeat (CFG_CYC + 2) @(negedge clk);
    pulse(WARM_MIN);
    repeat (REC_CYC + 8) @(negedge clk);
    chk("R11 warm width rejected", access_en, 0);
    chk("R11 por kind", por_kind, 1);
    pulse(POR_MIN);
    expect_recover("R11 por accepted");
    chk("R11 kind cleared", por_kind, 0);

    summary();
  end
endmodule